// File: doc/BRIEF.md
# Card Reset Release and Boot Strap Sequencer

This block brings a multi-DSP card out of reset in a fixed order once the card is powered. It waits until two inputs are both high: on-card rail power-good and the host slot's ready line. It then releases three classes of reset, one after another, with fixed gaps between them. The first class covers the PCIe switch, the Ethernet PHY and the per-DSP reset lines. The second is the power-on reset shared by the DSPs. The third is the DSP full reset.

Around the last release the block drives a 14-bit boot-strap word onto the DSP GPIO bus. A 4-bit configuration switch selects the word. A fixed hold time after the full reset is released, the block stops driving the bus by dropping its output-enable, and it raises a completion flag. If either power input falls at any point, every reset re-asserts at once, the strap bus is driven again and the sequence starts over.

The state machine has five states:
- `ST_WAIT`: everything held in reset, strap driven.
- `ST_PERIPH`: first class released.
- `ST_POR`: power-on reset released.
- `ST_FULL`: full reset released, strap still driven.
- `ST_DONE`: strap released, done flag high.

The transitions are:
- power-ok takes `ST_WAIT` to `ST_PERIPH`.
- Timer expiry moves `ST_PERIPH` to `ST_POR`, `ST_POR` to `ST_FULL`, and `ST_FULL` to `ST_DONE`.
- Loss of power-ok takes any state back to `ST_WAIT`.

All three inputs pass through a two-flop synchronizer. Each output therefore changes on the third rising clock edge after the input pin that caused it. Gap lengths are parameters in milliseconds, scaled by the parameter `CYC_PER_MS`.

Top module: `rsq_boot_seq`

## Requirements
- R1: While `rst_n` is low, and after it is released with both power inputs low, all reset outputs are low (asserted), `strap_oe_o` is 1 and `seq_done_o` is 0.
- R2: The sequence starts only when `rail_pg_i` and `slot_rdy_i` are both high. The first release appears on the third rising edge after the later of the two goes high. If only one input is high, nothing is released.
- R3: `sw_rst_n_o`, `phy_rst_n_o` and every bit of `dsp_rst_n_o` go high on the same clock edge, while `dsp_por_n_o` is still low.
- R4: `dsp_por_n_o` goes high exactly `POR_GAP_MS*CYC_PER_MS` cycles after the R3 release.
- R5: `dsp_full_rst_n_o` goes high exactly `FULL_GAP_MS*CYC_PER_MS` cycles after `dsp_por_n_o`.
- R6: `strap_oe_o` stays 1 when the full reset is released. Exactly `HOLD_MS*CYC_PER_MS` cycles later, `strap_oe_o` drops to 0 and `seq_done_o` rises to 1.
- R7: `strap_data_o[0]` equals switch bit `cfg_sw_i[0]`. The value 0 selects big endian and the value 1 selects little endian.
- R8: `cfg_sw_i[3:1]` selects the pattern on `strap_data_o[13:1]`:
  - 000 selects no boot, pattern 13'h0000.
  - 001 selects serial-EEPROM boot, pattern 13'h0405.
  - 010 selects PCIe boot, pattern 13'h1804.
- R9: Codes 011 through 111 are reserved. They produce pattern 13'h0000 on `strap_data_o[13:1]` and set `cfg_err_o` to 1. Codes 000, 001 and 010 give `cfg_err_o` = 0.
- R10: If either power input goes low in any state, all reset outputs are low, `strap_oe_o` is 1 and `seq_done_o` is 0 on the third rising edge after the drop. When both inputs are high again, the whole sequence runs again from the start.
- R11: The switch value is captured once, on the edge where the sequence starts. A later change of `cfg_sw_i` does not alter `strap_data_o` or `cfg_err_o` until the block returns to the wait state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Asynchronous active-low reset of the sequencer |
| rail_pg_i | input | 1 | On-card rails good, active high |
| slot_rdy_i | input | 1 | Host slot power-ok / reset line, high = ready |
| cfg_sw_i | input | 4 | Configuration switch: [0] endian, [3:1] boot code |
| sw_rst_n_o | output | 1 | PCIe switch reset, active low |
| phy_rst_n_o | output | 1 | Ethernet PHY reset, active low |
| dsp_rst_n_o | output | NUM_DSP | Per-DSP reset lines, active low |
| dsp_por_n_o | output | 1 | Shared DSP power-on reset, active low |
| dsp_full_rst_n_o | output | 1 | Shared DSP full reset, active low |
| strap_data_o | output | 14 | Boot-strap word for the DSP GPIO bus |
| strap_oe_o | output | 1 | Strap bus output-enable; 0 = bus released |
| seq_done_o | output | 1 | Sequence complete |
| cfg_err_o | output | 1 | Reserved boot code selected |

## Verification
The bench aims at exact cycle counts for every release. A timer that is off by one would move one release by a cycle and break the expected event schedule. It also tries power loss in the middle of the power-on gap and after completion. A design that failed to return to the wait state would leave a reset released or the strap bus floating, and a design that did not rearm its timer would restart with a wrong gap. It flips the switch halfway through a sequence; a design that kept sampling would publish the new pattern at full-reset release. Finally, it applies a reserved boot code, which must give a zero pattern with the error flag set rather than a stray strap word.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

    // Width of the strap bus; bit 0 carries byte order, 13:1 the boot pattern
    localparam int STRAP_W = 14;
    localparam int PAT_W   = STRAP_W - 1;

    // Boot patterns placed on strap bits 13:1
    localparam logic [PAT_W-1:0] PAT_NO_BOOT   = 13'h0000;
    localparam logic [PAT_W-1:0] PAT_EEPROM    = 13'h0405;
    localparam logic [PAT_W-1:0] PAT_PCIE_BOOT = 13'h1804;

    // Boot codes taken from switch bits 3:1
    localparam logic [2:0] CODE_NONE   = 3'b000;
    localparam logic [2:0] CODE_EEPROM = 3'b001;
    localparam logic [2:0] CODE_PCIE   = 3'b010;

    typedef enum logic [2:0] {
        ST_WAIT   = 3'd0,
        ST_PERIPH = 3'd1,
        ST_POR    = 3'd2,
        ST_FULL   = 3'd3,
        ST_DONE   = 3'd4
    } seq_state_e;

    typedef struct packed {
        logic [PAT_W-1:0] mode_bits;
        logic             little_end;
    } strap_word_t;

endpackage

// File: rtl/rsq_sync.sv
module rsq_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);

    logic [W-1:0] meta_q;
    logic [W-1:0] stable_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta_q   <= '0;
            stable_q <= '0;
        end else begin
            meta_q   <= async_i;
            stable_q <= meta_q;
        end
    end

    assign sync_o = stable_q;

endmodule

// File: rtl/rsq_interval.sv
module rsq_interval #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] len,
    output logic             expire
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    // Loading len-1 keeps the owning state active for exactly len cycles
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= len - ONE;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - ONE;
        end
    end

    assign expire = (cnt_q == '0);

endmodule

// File: rtl/rsq_strap_dec.sv
module rsq_strap_dec
    import rsq_pkg::*;
(
    input  logic [3:0]  sw,
    output strap_word_t word,
    output logic        bad_code
);

    logic [2:0] code;
    assign code = sw[3:1];

    always_comb begin
        word.little_end = sw[0];
        bad_code        = 1'b0;
        unique case (code)
            CODE_NONE:   word.mode_bits = PAT_NO_BOOT;
            CODE_EEPROM: word.mode_bits = PAT_EEPROM;
            CODE_PCIE:   word.mode_bits = PAT_PCIE_BOOT;
            default: begin
                word.mode_bits = PAT_NO_BOOT;
                bad_code       = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/rsq_boot_seq.sv
module rsq_boot_seq
    import rsq_pkg::*;
#(
    parameter int NUM_DSP     = 4,
    parameter int CYC_PER_MS  = 100000,
    parameter int POR_GAP_MS  = 5,
    parameter int FULL_GAP_MS = 5,
    parameter int HOLD_MS     = 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rail_pg_i,
    input  logic               slot_rdy_i,
    input  logic [3:0]         cfg_sw_i,
    output logic               sw_rst_n_o,
    output logic               phy_rst_n_o,
    output logic [NUM_DSP-1:0] dsp_rst_n_o,
    output logic               dsp_por_n_o,
    output logic               dsp_full_rst_n_o,
    output logic [STRAP_W-1:0] strap_data_o,
    output logic               strap_oe_o,
    output logic               seq_done_o,
    output logic               cfg_err_o
);

    localparam int POR_CYC  = CYC_PER_MS * POR_GAP_MS;
    localparam int FULL_CYC = CYC_PER_MS * FULL_GAP_MS;
    localparam int HOLD_CYC = CYC_PER_MS * HOLD_MS;
    localparam int MAX_CYC  = (POR_CYC > FULL_CYC) ?
                              ((POR_CYC > HOLD_CYC) ? POR_CYC : HOLD_CYC) :
                              ((FULL_CYC > HOLD_CYC) ? FULL_CYC : HOLD_CYC);
    localparam int CNT_W    = $clog2(MAX_CYC + 1);
    localparam int IN_W     = 6;

    localparam logic [CNT_W-1:0] POR_LEN  = CNT_W'(POR_CYC);
    localparam logic [CNT_W-1:0] FULL_LEN = CNT_W'(FULL_CYC);
    localparam logic [CNT_W-1:0] HOLD_LEN = CNT_W'(HOLD_CYC);
    localparam logic [CNT_W-1:0] ONE_LEN  = CNT_W'(1);

    // ---------------- input synchronization ----------------
    logic [IN_W-1:0] raw_in;
    logic [IN_W-1:0] syn_in;
    logic            pg_s;
    logic            slot_s;
    logic [3:0]      sw_s;
    logic            power_ok;

    assign raw_in = {cfg_sw_i, slot_rdy_i, rail_pg_i};

    rsq_sync #(.W(IN_W)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (raw_in),
        .sync_o  (syn_in)
    );

    assign pg_s     = syn_in[0];
    assign slot_s   = syn_in[1];
    assign sw_s     = syn_in[5:2];
    assign power_ok = pg_s & slot_s;

    // ---------------- state machine ----------------
    seq_state_e       state_q;
    seq_state_e       state_d;
    logic             tmr_load;
    logic             tmr_expire;
    logic [CNT_W-1:0] tmr_len;

    always_comb begin
        state_d = state_q;
        if (!power_ok) begin
            state_d = ST_WAIT;
        end else begin
            unique case (state_q)
                ST_WAIT:   state_d = ST_PERIPH;
                ST_PERIPH: if (tmr_expire) state_d = ST_POR;
                ST_POR:    if (tmr_expire) state_d = ST_FULL;
                ST_FULL:   if (tmr_expire) state_d = ST_DONE;
                ST_DONE:   state_d = ST_DONE;
                default:   state_d = ST_WAIT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_WAIT;
        end else begin
            state_q <= state_d;
        end
    end

    // The timer is rearmed on every state change with the length of the state being entered
    assign tmr_load = (state_d != state_q);

    always_comb begin
        unique case (state_d)
            ST_PERIPH: tmr_len = POR_LEN;
            ST_POR:    tmr_len = FULL_LEN;
            ST_FULL:   tmr_len = HOLD_LEN;
            default:   tmr_len = ONE_LEN;
        endcase
    end

    rsq_interval #(.CNT_W(CNT_W)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (tmr_load),
        .len    (tmr_len),
        .expire (tmr_expire)
    );

    // ---------------- configuration capture and decode ----------------
    logic [3:0]  cfg_q;
    strap_word_t strap_w;
    logic        bad_code;

    // The switch is followed only while waiting; the start edge freezes it
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (state_q == ST_WAIT) begin
            cfg_q <= sw_s;
        end
    end

    rsq_strap_dec u_dec (
        .sw       (cfg_q),
        .word     (strap_w),
        .bad_code (bad_code)
    );

    assign strap_data_o = strap_w;
    assign cfg_err_o    = bad_code;

    // ---------------- registered outputs ----------------
    logic periph_rel_q;
    logic por_rel_q;
    logic full_rel_q;
    logic oe_q;
    logic done_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            periph_rel_q <= 1'b0;
            por_rel_q    <= 1'b0;
            full_rel_q   <= 1'b0;
            oe_q         <= 1'b1;
            done_q       <= 1'b0;
        end else begin
            periph_rel_q <= (state_d != ST_WAIT);
            por_rel_q    <= (state_d == ST_POR) || (state_d == ST_FULL) ||
                            (state_d == ST_DONE);
            full_rel_q   <= (state_d == ST_FULL) || (state_d == ST_DONE);
            oe_q         <= (state_d != ST_DONE);
            done_q       <= (state_d == ST_DONE);
        end
    end

    assign sw_rst_n_o       = periph_rel_q;
    assign phy_rst_n_o      = periph_rel_q;
    assign dsp_por_n_o      = por_rel_q;
    assign dsp_full_rst_n_o = full_rel_q;
    assign strap_oe_o       = oe_q;
    assign seq_done_o       = done_q;

    for (genvar gi = 0; gi < NUM_DSP; gi++) begin : g_dsp_rst
        assign dsp_rst_n_o[gi] = periph_rel_q;
    end

    // ---------------- checks ----------------
    logic [CNT_W:0] por_gap_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            por_gap_cnt <= '0;
        end else if (sw_rst_n_o && !dsp_por_n_o) begin
            por_gap_cnt <= por_gap_cnt + 1'b1;
        end else begin
            por_gap_cnt <= '0;
        end
    end

    // R4
    por_gap_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dsp_por_n_o) |-> (por_gap_cnt == (CNT_W+1)'(POR_CYC)));

    // R4
    por_after_periph_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dsp_por_n_o |-> sw_rst_n_o);

    // R5
    full_after_por_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dsp_full_rst_n_o |-> dsp_por_n_o);

    // R6
    strap_driven_at_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dsp_full_rst_n_o) |-> strap_oe_o);

    // R6
    done_releases_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done_o |-> (!strap_oe_o && dsp_full_rst_n_o));

    // R9
    reserved_zero_pat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err_o |-> (strap_data_o[STRAP_W-1:1] == '0));

    // R10
    drop_rearms_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !power_ok |=> (!sw_rst_n_o && !dsp_por_n_o && !dsp_full_rst_n_o &&
                       strap_oe_o && !seq_done_o));

    // R11
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_WAIT) |=> $stable(cfg_q));

endmodule

// File: tb/rsq_boot_seq_tb.sv
module rsq_boot_seq_tb;

    localparam int NUM_DSP = 4;
    localparam int MS      = 10;
    localparam int G_POR   = 5 * MS;
    localparam int G_FULL  = 5 * MS;
    localparam int G_HOLD  = 1 * MS;
    localparam int LAT     = 3;

    localparam int EV_PERIPH = 0;
    localparam int EV_POR    = 1;
    localparam int EV_FULL   = 2;
    localparam int EV_DONE   = 3;

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               rail_pg_i = 1'b0;
    logic               slot_rdy_i = 1'b0;
    logic [3:0]         cfg_sw_i = 4'b0000;
    logic               sw_rst_n_o;
    logic               phy_rst_n_o;
    logic [NUM_DSP-1:0] dsp_rst_n_o;
    logic               dsp_por_n_o;
    logic               dsp_full_rst_n_o;
    logic [13:0]        strap_data_o;
    logic               strap_oe_o;
    logic               seq_done_o;
    logic               cfg_err_o;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    typedef struct {
        int          kind;
        int          at;
        logic [13:0] strap;
        logic        err;
    } exp_t;

    exp_t exp_q[$];

    rsq_boot_seq #(
        .NUM_DSP     (NUM_DSP),
        .CYC_PER_MS  (MS),
        .POR_GAP_MS  (5),
        .FULL_GAP_MS (5),
        .HOLD_MS     (1)
    ) u_dut (
        .clk              (clk),
        .rst_n            (rst_n),
        .rail_pg_i        (rail_pg_i),
        .slot_rdy_i       (slot_rdy_i),
        .cfg_sw_i         (cfg_sw_i),
        .sw_rst_n_o       (sw_rst_n_o),
        .phy_rst_n_o      (phy_rst_n_o),
        .dsp_rst_n_o      (dsp_rst_n_o),
        .dsp_por_n_o      (dsp_por_n_o),
        .dsp_full_rst_n_o (dsp_full_rst_n_o),
        .strap_data_o     (strap_data_o),
        .strap_oe_o       (strap_oe_o),
        .seq_done_o       (seq_done_o),
        .cfg_err_o        (cfg_err_o)
    );

    always #4 clk = ~clk;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // Expected strap word from R7/R8/R9
    function automatic logic [13:0] ref_strap(input logic [3:0] sw);
        logic [12:0] pat;
        case (sw[3:1])
            3'b001:  pat = 13'h0405;
            3'b010:  pat = 13'h1804;
            default: pat = 13'h0000;
        endcase
        return {pat, sw[0]};
    endfunction

    function automatic logic ref_err(input logic [3:0] sw);
        return (sw[3:1] > 3'b010);
    endfunction

    // Driver: raise both power inputs and push the expected release schedule
    task automatic go(input logic [3:0] sw, input int n_items);
        int   c;
        exp_t e;
        @(negedge clk);
        cfg_sw_i = sw;
        repeat (4) @(negedge clk);
        c = cyc;
        rail_pg_i  = 1'b1;
        slot_rdy_i = 1'b1;
        e.strap = ref_strap(sw);
        e.err   = ref_err(sw);
        for (int k = 0; k < n_items; k++) begin
            e.kind = k;
            case (k)
                0:       e.at = c + LAT;
                1:       e.at = c + LAT + G_POR;
                2:       e.at = c + LAT + G_POR + G_FULL;
                default: e.at = c + LAT + G_POR + G_FULL + G_HOLD;
            endcase
            exp_q.push_back(e);
        end
    endtask

    task automatic drain();
        wait (exp_q.size() == 0);
        repeat (2) @(negedge clk);
    endtask

    // R10: drop one power input and check everything re-asserts
    task automatic drop_chk(input bit use_pg);
        @(negedge clk);
        if (use_pg) rail_pg_i = 1'b0;
        else        slot_rdy_i = 1'b0;
        repeat (LAT) @(negedge clk);
        chk("R10 switch/phy reset", int'(sw_rst_n_o | phy_rst_n_o), 0);
        chk("R10 dsp resets", int'(|dsp_rst_n_o), 0);
        chk("R10 por/full", int'(dsp_por_n_o | dsp_full_rst_n_o), 0);
        chk("R10 strap oe", int'(strap_oe_o), 1);
        chk("R10 done", int'(seq_done_o), 0);
    endtask

    // Monitor: detect release events and compare with the scoreboard
    logic prev_sw = 1'b0, prev_por = 1'b0, prev_full = 1'b0, prev_done = 1'b0;

    task automatic on_event(input int kind);
        exp_t e;
        if (exp_q.size() == 0) begin
            total++;
            bad++;
            $display("FAIL R2 unexpected event: actual=%0d expected=none (cycle %0d)", kind, cyc);
            return;
        end
        e = exp_q.pop_front();
        chk("R2 event order", kind, e.kind);
        case (kind)
            EV_PERIPH: begin
                chk("R2 start cycle", cyc, e.at);
                chk("R3 phy with switch", int'(phy_rst_n_o), 1);
                chk("R3 all dsp lines", int'(&dsp_rst_n_o), 1);
                chk("R3 por still held", int'(dsp_por_n_o), 0);
            end
            EV_POR:  chk("R4 por release cycle", cyc, e.at);
            EV_FULL: begin
                chk("R5 full release cycle", cyc, e.at);
                chk("R6 strap driven", int'(strap_oe_o), 1);
                chk("R7 endian bit", int'(strap_data_o[0]), int'(e.strap[0]));
                chk("R8 boot pattern", int'(strap_data_o[13:1]), int'(e.strap[13:1]));
                chk("R9 cfg error", int'(cfg_err_o), int'(e.err));
            end
            default: begin
                chk("R6 done cycle", cyc, e.at);
                chk("R6 strap released", int'(strap_oe_o), 0);
            end
        endcase
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (sw_rst_n_o && !prev_sw)        on_event(EV_PERIPH);
            if (dsp_por_n_o && !prev_por)      on_event(EV_POR);
            if (dsp_full_rst_n_o && !prev_full) on_event(EV_FULL);
            if (seq_done_o && !prev_done)      on_event(EV_DONE);
        end
        prev_sw   = sw_rst_n_o;
        prev_por  = dsp_por_n_o;
        prev_full = dsp_full_rst_n_o;
        prev_done = seq_done_o;
    end

    initial begin
        repeat (50000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog: actual=hung expected=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        // R1 reset state
        repeat (3) @(negedge clk);
        chk("R1 resets during rst", int'(sw_rst_n_o | dsp_por_n_o | dsp_full_rst_n_o), 0);
        chk("R1 oe during rst", int'(strap_oe_o), 1);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk("R1 resets after rst", int'(sw_rst_n_o | phy_rst_n_o | (|dsp_rst_n_o)), 0);
        chk("R1 oe/done", int'({strap_oe_o, seq_done_o}), 2);

        // R2 one input alone does nothing
        rail_pg_i = 1'b1;
        repeat (20) @(negedge clk);
        chk("R2 pg only", int'(sw_rst_n_o), 0);
        rail_pg_i  = 1'b0;
        slot_rdy_i = 1'b1;
        repeat (20) @(negedge clk);
        chk("R2 slot only", int'(sw_rst_n_o), 0);
        slot_rdy_i = 1'b0;
        repeat (5) @(negedge clk);

        // Full sequences with different switch settings (R7, R8)
        go(4'b0011, 4);  // eeprom boot, little endian
        drain();
        drop_chk(1'b0);  // R10 after done
        go(4'b0100, 4);  // pcie boot, big endian
        drain();
        drop_chk(1'b1);
        go(4'b0000, 4);  // no boot, big endian
        drain();
        drop_chk(1'b0);
        go(4'b1111, 4);  // R9 reserved code
        drain();
        drop_chk(1'b0);
        go(4'b0110, 4);  // R9 reserved code, big endian
        drain();
        drop_chk(1'b1);

        // R11 switch change mid-sequence has no effect
        go(4'b0101, 4);
        repeat (10) @(negedge clk);
        cfg_sw_i = 4'b0010;
        drain();
        chk("R11 strap after change", int'(strap_data_o), int'(ref_strap(4'b0101)));
        chk("R11 err after change", int'(cfg_err_o), 0);
        drop_chk(1'b0);

        // R10 drop in the middle of the por gap, then restart
        go(4'b0011, 1);
        drain();
        repeat (20) @(negedge clk);
        drop_chk(1'b1);
        repeat (5) @(negedge clk);
        go(4'b0011, 4);
        drain();
        chk("R10 restart done", int'(seq_done_o), 1);
        chk("R2 scoreboard empty", exp_q.size(), 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule